// File: doc/BRIEF.md
# Single-Wire Half-Duplex Serial Link Engine

This block runs a byte-oriented, 8N1 asynchronous link over one shared open-drain wire at a nominal 9600 bit/s. The wire is pulled low by whichever side is sending and is otherwise released to its pull-up. Received bytes go to the core as a byte stream with a one-cycle valid strobe, and the core offers bytes to send through a valid/ready handshake. The receiver oversamples the wire sixteen times per bit. The engine also reports when a host message has ended, which it infers from an idle gap after the last byte.

The engine also handles three line events by itself. A long continuous low inside a set window is taken as a break. It answers with a 0x55 calibration byte after a fixed delay, then stays in calibration mode for a fixed hold time. A low that outlasts the receive timeout without being a break makes the engine abandon the byte and answer with a NACK byte. A short framing error is dropped without any reply. After reset the engine waits a power-up delay and then sends a power-on byte by itself.

All time limits are given in oversample ticks. With the default tick of about 6.5 us, the defaults are: receive timeout 1.45 ms, break window 1.29 to 2.0 ms, calibration reply delay 1 ms, calibration hold 2 ms, message gap 1.3 ms, power-on delay 8 ms.

Top module: `swl_link`

## Requirements
- R1: Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit, each lasting OVS ticks. `line_low_o` = 1 means the engine pulls the wire low.
- R2: A receive frame starts at the first low tick sample. The start bit is confirmed only if the wire is still low on the eighth tick sample, so shorter glitches are ignored. A frame whose stop sample is high delivers its byte on `rx_data_o`, together with a single-cycle `rx_valid_o`.
- R3: If the stop sample is low and the low run ends after fewer than BRK_MIN low tick samples, the byte is dropped. No strobe, no reply and no calibration follow.
- R4: If the low run lasts from BRK_MIN to BRK_MAX tick samples, it is a break. `abd_active_o` rises, and ABD_DLY ticks after the wire is released the engine sends 0x55. `abd_active_o` then stays high for ABD_EXIT ticks after that frame's stop bit ends. While it is high, `tx_ready_o` is low and received frames are ignored.
- R5: If the low run lasts at least RX_TOUT tick samples and is not a break, the byte is abandoned and NACK_BYTE (default 0x15) is sent once the wire is released.
- R6: `rx_eom_o` pulses once when MSG_GAP ticks pass after a delivered byte's stop sample with no new start. A new start inside the gap cancels the pulse.
- R7: `tx_ready_o` is high only when the engine is idle, not receiving and not in calibration mode. An accepted byte starts its start bit within two ticks, and `tx_ready_o` stays low until that frame ends.
- R8: The engine's own transmitted frames are never decoded as received bytes.
- R9: After reset the wire stays released and `tx_ready_o` stays low for POR_DLY ticks. Then POR_BYTE (default 0xC3) is sent, and after it the engine becomes ready.
- R10: During reset the wire is released and `rx_valid_o`, `rx_eom_o`, `tx_ready_o` and `abd_active_o` are low. The engine never pulls the wire while a receive frame is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Sensed level of the shared wire |
| line_low_o | output | 1 | 1 pulls the shared wire low |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_eom_o | output | 1 | One-cycle strobe at end of a host message |
| tx_data_i | input | 8 | Byte offered by the core |
| tx_valid_i | input | 1 | Core offers `tx_data_i` |
| tx_ready_o | output | 1 | Engine accepts the offered byte this cycle |
| abd_active_o | output | 1 | Calibration (break reply) mode active |

## Verification
The bench classifies low runs of three lengths that straddle the break window and the timeout. A design that compared against the wrong bound would answer a short framing error, would NACK a valid break, or would calibrate on a stuck wire. It times the power-on byte, the 0x55 reply delay and the calibration hold. An off-by-one tick counter or a hold measured from the wrong edge would shift these past the allowed windows. It also checks that the end-of-message strobe is cancelled by a second byte and fires only after a full gap. It checks that the engine's own echo, and host bytes sent during calibration, produce no received byte. A design that left its receiver running while it transmits would report phantom bytes.

// File: rtl/swl_pkg.sv
package swl_pkg;

    localparam int BYTE_W  = 8;
    localparam int FRAME_W = BYTE_W + 2;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_LOWRUN
    } rx_state_e;

    typedef enum logic [2:0] {
        CT_POR,
        CT_POR_TX,
        CT_IDLE,
        CT_TX,
        CT_ABD_WAIT,
        CT_ABD_TX,
        CT_ABD_HOLD
    } ctl_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/swl_tick.sv
module swl_tick #(
    parameter int CLKS_PER_TICK = 326
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = $clog2(CLKS_PER_TICK + 1);
    localparam logic [W-1:0] LAST = W'(CLKS_PER_TICK - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tick;
    } tk_s;

    tk_s d, q;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        if (q.cnt == LAST) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = q.tick;
endmodule

// File: rtl/swl_rx.sv
module swl_rx
    import swl_pkg::*;
#(
    parameter int OVS     = 16,
    parameter int RX_TOUT = 223,
    parameter int BRK_MIN = 198,
    parameter int BRK_MAX = 307
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              line_i,
    output logic              busy_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              valid_o,
    output logic              brk_o,
    output logic              nack_o
);
    localparam int SW  = $clog2(OVS);
    localparam int IW  = $clog2(BYTE_W);
    localparam int LIM = imax(BRK_MAX, RX_TOUT) + 1;
    localparam int TW  = $clog2(LIM + 1);
    localparam logic [SW-1:0] MID_M1 = SW'(OVS / 2 - 2);
    localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(BYTE_W - 1);
    localparam logic [TW-1:0] RUN_SAT = TW'(LIM);
    localparam logic [TW-1:0] BMIN_C = TW'(BRK_MIN);
    localparam logic [TW-1:0] BMAX_C = TW'(BRK_MAX);
    localparam logic [TW-1:0] TOUT_C = TW'(RX_TOUT);

    typedef struct packed {
        rx_state_e         st;
        logic [SW-1:0]     sub;
        logic [IW-1:0]     idx;
        logic [BYTE_W-1:0] sr;
        logic [TW-1:0]     run;
        logic              valid;
        logic              brk;
        logic              nack;
    } rx_s;

    rx_s d, q;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.brk   = 1'b0;
        d.nack  = 1'b0;
        if (!en_i) begin
            d.st = RX_IDLE;
        end else if (tick_i) begin
            if (q.run != RUN_SAT) d.run = q.run + 1'b1;
            unique case (q.st)
                RX_IDLE: begin
                    if (!line_i) begin
                        d.st  = RX_START;
                        d.sub = '0;
                        d.run = TW'(1);
                    end
                end
                RX_START: begin
                    if (q.sub == MID_M1) begin
                        d.sub = '0;
                        d.idx = '0;
                        d.st  = line_i ? RX_IDLE : RX_DATA;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (q.sub == SUB_LAST) begin
                        d.sub = '0;
                        d.sr  = {line_i, q.sr[BYTE_W-1:1]};
                        if (q.idx == IDX_LAST) d.st = RX_STOP;
                        else                   d.idx = q.idx + 1'b1;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (q.sub == SUB_LAST) begin
                        if (line_i) begin
                            d.st    = RX_IDLE;
                            d.valid = 1'b1;
                        end else begin
                            d.st = RX_LOWRUN;
                        end
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                RX_LOWRUN: begin
                    if (line_i) begin
                        d.st  = RX_IDLE;
                        d.run = q.run;
                        if (q.run >= BMIN_C && q.run <= BMAX_C) d.brk = 1'b1;
                        else if (q.run >= TOUT_C)               d.nack = 1'b1;
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RX_IDLE, default: '0};
        else        q <= d;
    end

    assign busy_o  = (q.st != RX_IDLE);
    assign data_o  = q.sr;
    assign valid_o = q.valid;
    assign brk_o   = q.brk;
    assign nack_o  = q.nack;
endmodule

// File: rtl/swl_tx.sv
module swl_tx
    import swl_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              go_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              line_low_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int SW = $clog2(OVS);
    localparam int IW = $clog2(FRAME_W);
    localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_W - 1);

    typedef struct packed {
        logic               pend;
        logic               act;
        logic [SW-1:0]      sub;
        logic [IW-1:0]      idx;
        logic [FRAME_W-1:0] sr;
        logic               done;
    } tx_s;

    tx_s d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (go_i && !q.pend && !q.act) begin
            d.pend = 1'b1;
            d.sr   = {1'b1, byte_i, 1'b0};
        end
        if (tick_i) begin
            if (q.pend) begin
                d.pend = 1'b0;
                d.act  = 1'b1;
                d.sub  = '0;
                d.idx  = '0;
            end else if (q.act) begin
                if (q.sub == SUB_LAST) begin
                    d.sub = '0;
                    if (q.idx == IDX_LAST) begin
                        d.act  = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.sr  = {1'b1, q.sr[FRAME_W-1:1]};
                    end
                end else begin
                    d.sub = q.sub + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line_low_o = q.act & ~q.sr[0];
    assign busy_o     = q.pend | q.act;
    assign done_o     = q.done;
endmodule

// File: rtl/swl_link.sv
module swl_link
    import swl_pkg::*;
#(
    parameter int          CLKS_PER_TICK = 326,
    parameter int          OVS           = 16,
    parameter int          RX_TOUT       = 223,
    parameter int          BRK_MIN       = 198,
    parameter int          BRK_MAX       = 307,
    parameter int          ABD_DLY       = 154,
    parameter int          ABD_EXIT      = 307,
    parameter int          MSG_GAP       = 200,
    parameter int          POR_DLY       = 1229,
    parameter logic [7:0]  NACK_BYTE     = 8'h15,
    parameter logic [7:0]  POR_BYTE      = 8'hC3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    output logic       line_low_o,
    output logic [7:0] rx_data_o,
    output logic       rx_valid_o,
    output logic       rx_eom_o,
    input  logic [7:0] tx_data_i,
    input  logic       tx_valid_i,
    output logic       tx_ready_o,
    output logic       abd_active_o
);
    localparam int CMAX = imax(imax(POR_DLY, MSG_GAP), imax(ABD_DLY, ABD_EXIT));
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] POR_LAST = CW'(POR_DLY - 1);
    localparam logic [CW-1:0] ABD_LAST = CW'(ABD_DLY - 1);
    localparam logic [CW-1:0] EXIT_LAST = CW'(ABD_EXIT - 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(MSG_GAP - 1);
    localparam logic [7:0]    CAL_BYTE = 8'h55;

    typedef struct packed {
        ctl_state_e    st;
        logic [CW-1:0] wcnt;
        logic          gap_act;
        logic [CW-1:0] gap_cnt;
        logic          eom;
        logic [1:0]    sync;
    } ctl_s;

    ctl_s d, q;

    logic              tick;
    logic              rx_busy, rx_valid, rx_brk, rx_nack;
    logic [BYTE_W-1:0] rx_data;
    logic              tx_go, tx_busy, tx_done;
    logic [BYTE_W-1:0] tx_byte;

    swl_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) i_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    swl_rx #(.OVS(OVS), .RX_TOUT(RX_TOUT), .BRK_MIN(BRK_MIN), .BRK_MAX(BRK_MAX)) i_rx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(q.st == CT_IDLE),
        .line_i(q.sync[1]), .busy_o(rx_busy), .data_o(rx_data),
        .valid_o(rx_valid), .brk_o(rx_brk), .nack_o(rx_nack)
    );

    swl_tx #(.OVS(OVS)) i_tx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .go_i(tx_go), .byte_i(tx_byte),
        .line_low_o(line_low_o), .busy_o(tx_busy), .done_o(tx_done)
    );

    always_comb begin
        d          = q;
        d.eom      = 1'b0;
        d.sync     = {q.sync[0], line_i};
        tx_go      = 1'b0;
        tx_byte    = NACK_BYTE;
        tx_ready_o = (q.st == CT_IDLE) && !rx_busy && !rx_brk && !rx_nack && !tx_busy;

        unique case (q.st)
            CT_POR: begin
                if (tick) begin
                    if (q.wcnt == POR_LAST) begin
                        tx_go   = 1'b1;
                        tx_byte = POR_BYTE;
                        d.st    = CT_POR_TX;
                    end else begin
                        d.wcnt = q.wcnt + 1'b1;
                    end
                end
            end
            CT_POR_TX, CT_TX: begin
                if (tx_done) d.st = CT_IDLE;
            end
            CT_IDLE: begin
                if (rx_brk) begin
                    d.st   = CT_ABD_WAIT;
                    d.wcnt = '0;
                end else if (rx_nack) begin
                    tx_go   = 1'b1;
                    tx_byte = NACK_BYTE;
                    d.st    = CT_TX;
                end else if (tx_valid_i && tx_ready_o) begin
                    tx_go   = 1'b1;
                    tx_byte = tx_data_i;
                    d.st    = CT_TX;
                end
            end
            CT_ABD_WAIT: begin
                if (tick) begin
                    if (q.wcnt == ABD_LAST) begin
                        tx_go   = 1'b1;
                        tx_byte = CAL_BYTE;
                        d.st    = CT_ABD_TX;
                    end else begin
                        d.wcnt = q.wcnt + 1'b1;
                    end
                end
            end
            CT_ABD_TX: begin
                if (tx_done) begin
                    d.st   = CT_ABD_HOLD;
                    d.wcnt = '0;
                end
            end
            CT_ABD_HOLD: begin
                if (tick) begin
                    if (q.wcnt == EXIT_LAST) d.st = CT_IDLE;
                    else                     d.wcnt = q.wcnt + 1'b1;
                end
            end
            default: d.st = CT_IDLE;
        endcase

        if (rx_valid) begin
            d.gap_act = 1'b1;
            d.gap_cnt = '0;
        end else if (rx_busy || rx_brk || rx_nack) begin
            d.gap_act = 1'b0;
        end else if (tick && q.gap_act) begin
            if (q.gap_cnt == GAP_LAST) begin
                d.eom     = 1'b1;
                d.gap_act = 1'b0;
            end else begin
                d.gap_cnt = q.gap_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: CT_POR, sync: 2'b11, default: '0};
        else        q <= d;
    end

    assign rx_data_o    = rx_data;
    assign rx_valid_o   = rx_valid;
    assign rx_eom_o     = q.eom;
    assign abd_active_o = (q.st == CT_ABD_WAIT) || (q.st == CT_ABD_TX) || (q.st == CT_ABD_HOLD);
endmodule

// File: rtl/swl_link_chk.sv
module swl_link_chk #(
    parameter int POR_DLY = 1229
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic line_low,
    input logic rx_busy,
    input logic rx_valid,
    input logic rx_eom,
    input logic tx_ready,
    input logic abd_active
);
    localparam int PW = $clog2(POR_DLY + 2);
    localparam logic [PW-1:0] POR_C = PW'(POR_DLY);

    logic [PW-1:0] ticks_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      ticks_q <= '0;
        else if (tick && ticks_q != POR_C) ticks_q <= ticks_q + 1'b1;
    end

    assert_no_drive_in_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_low && rx_busy));

    assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_eom_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eom |=> !rx_eom);

    assert_ready_blocked_cal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        abd_active |-> !tx_ready);

    assert_ready_line_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !line_low);

    assert_por_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ticks_q < POR_C) |-> (!line_low && !tx_ready));
endmodule

bind swl_link swl_link_chk #(.POR_DLY(POR_DLY)) i_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_low(line_low_o),
    .rx_busy(rx_busy), .rx_valid(rx_valid_o), .rx_eom(rx_eom_o),
    .tx_ready(tx_ready_o), .abd_active(abd_active_o)
);

// File: tb/test_swl_link.sv
module test_swl_link;
    localparam int CPT      = 4;
    localparam int OVS      = 16;
    localparam int BITC     = CPT * OVS;
    localparam int RX_TOUT  = 223;
    localparam int BRK_MIN  = 198;
    localparam int BRK_MAX  = 307;
    localparam int ABD_DLY  = 154;
    localparam int ABD_EXIT = 307;
    localparam int MSG_GAP  = 200;
    localparam int POR_DLY  = 1229;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_low = 1'b0;
    logic       dut_low;
    logic       line;
    logic [7:0] rx_data;
    logic       rx_valid, rx_eom, tx_ready, abd_active;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;

    int n_chk = 0, n_err = 0, rx_cnt = 0, eom_cnt = 0;
    logic [7:0] rx_last = '0;

    always #10 clk = ~clk;
    assign line = !(host_low || dut_low);

    swl_link #(
        .CLKS_PER_TICK(CPT), .OVS(OVS), .RX_TOUT(RX_TOUT), .BRK_MIN(BRK_MIN),
        .BRK_MAX(BRK_MAX), .ABD_DLY(ABD_DLY), .ABD_EXIT(ABD_EXIT),
        .MSG_GAP(MSG_GAP), .POR_DLY(POR_DLY), .NACK_BYTE(8'h15), .POR_BYTE(8'hC3)
    ) i_swl_link (
        .clk(clk), .rst_n(rst_n), .line_i(line), .line_low_o(dut_low),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_eom_o(rx_eom),
        .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
        .abd_active_o(abd_active)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data;
        end
        if (rst_n && rx_eom) eom_cnt <= eom_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 10; i++) begin
            host_low = (i == 0) ? 1'b1 : (i == 9) ? 1'b0 : !b[i-1];
            repeat (BITC) @(negedge clk);
        end
        host_low = 1'b0;
    endtask

    task automatic hold_low(input int ticks);
        host_low = 1'b1;
        repeat (ticks * CPT) @(negedge clk);
        host_low = 1'b0;
    endtask

    task automatic expect_tx(input logic [7:0] exp, input string req, input int limit,
                             output int waited);
        logic [7:0] b;
        waited = 0;
        while (!dut_low && waited < limit) begin
            @(negedge clk);
            waited++;
        end
        check(dut_low, req, "frame start seen", dut_low, 1);
        repeat (BITC / 2) @(negedge clk);
        check(dut_low, req, "start bit low at mid", dut_low, 1);
        for (int i = 0; i < 8; i++) begin
            repeat (BITC) @(negedge clk);
            b[i] = !dut_low;
        end
        repeat (BITC) @(negedge clk);
        check(b == exp, req, "sent byte", b, exp);
        check(!dut_low, req, "stop bit released", dut_low, 0);
    endtask

    task automatic t_reset_por();
        int w, t;
        repeat (5) @(negedge clk);
        check(!dut_low && !rx_valid && !rx_eom && !tx_ready && !abd_active, "R10",
              "outputs idle in reset", {dut_low, rx_valid, rx_eom, tx_ready, abd_active}, 0);
        rst_n = 1'b1;
        repeat (POR_DLY * CPT / 2) @(negedge clk);
        check(!tx_ready, "R9", "not ready during power-up wait", tx_ready, 0);
        t = POR_DLY * CPT / 2;
        expect_tx(8'hC3, "R9", POR_DLY * CPT, w);
        t += w;
        check(t >= POR_DLY * CPT && t <= POR_DLY * CPT + 16, "R9", "power-on byte delay",
              t, (POR_DLY + 1) * CPT);
        repeat (BITC) @(negedge clk);
        check(tx_ready, "R9", "ready after power-on byte", tx_ready, 1);
    endtask

    task automatic t_rx_and_gap();
        int c0 = rx_cnt, e0 = eom_cnt;
        send_byte(8'hA7);
        check(rx_cnt == c0 + 1 && rx_last == 8'hA7, "R2", "first byte", rx_last, 8'hA7);
        repeat (100 * CPT) @(negedge clk);
        send_byte(8'h3C);
        check(rx_cnt == c0 + 2 && rx_last == 8'h3C, "R1", "second byte lsb first", rx_last, 8'h3C);
        check(eom_cnt == e0, "R6", "gap inside message gives no end", eom_cnt - e0, 0);
        repeat (150 * CPT) @(negedge clk);
        check(eom_cnt == e0, "R6", "no end before full gap", eom_cnt - e0, 0);
        repeat (60 * CPT) @(negedge clk);
        check(eom_cnt == e0 + 1, "R6", "one end after full gap", eom_cnt - e0, 1);
    endtask

    task automatic t_glitch();
        int c0 = rx_cnt;
        hold_low(4);
        repeat (200) @(negedge clk);
        check(rx_cnt == c0 && !dut_low, "R2", "short glitch not a start", rx_cnt - c0, 0);
        send_byte(8'h01);
        check(rx_cnt == c0 + 1 && rx_last == 8'h01, "R2", "byte after glitch", rx_last, 8'h01);
        repeat (MSG_GAP * CPT + 40) @(negedge clk);
    endtask

    task automatic t_core_tx();
        int w, c0 = rx_cnt;
        tx_data  = 8'h96;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        check(!tx_ready, "R7", "ready low after accept", tx_ready, 0);
        expect_tx(8'h96, "R7", 4 * CPT, w);
        check(w <= 2 * CPT, "R7", "turnaround cycles", w, 2 * CPT);
        repeat (BITC) @(negedge clk);
        check(rx_cnt == c0, "R8", "own echo not received", rx_cnt - c0, 0);
    endtask

    task automatic t_framing_drop();
        int c0 = rx_cnt, seen = 0;
        hold_low(170);
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (dut_low || abd_active) seen++;
        end
        check(seen == 0, "R3", "short low run gives no reply", seen, 0);
        check(rx_cnt == c0, "R3", "short low run gives no byte", rx_cnt - c0, 0);
    endtask

    task automatic t_nack();
        int w, c0 = rx_cnt;
        hold_low(400);
        repeat (2) @(negedge clk);
        check(!abd_active, "R5", "overlong low is not a break", abd_active, 0);
        expect_tx(8'h15, "R5", 8 * CPT, w);
        check(rx_cnt == c0, "R5", "abandoned byte not delivered", rx_cnt - c0, 0);
        repeat (BITC) @(negedge clk);
    endtask

    task automatic t_autobaud();
        int w, t, c0 = rx_cnt;
        hold_low(250);
        repeat (CPT * 3) @(negedge clk);
        check(abd_active, "R4", "break enters calibration", abd_active, 1);
        check(!tx_ready, "R4", "core blocked in calibration", tx_ready, 0);
        expect_tx(8'h55, "R4", ABD_DLY * CPT + 100, w);
        w += CPT * 3;
        check(w >= ABD_DLY * CPT && w <= ABD_DLY * CPT + 20, "R4", "reply delay",
              w, (ABD_DLY + 1) * CPT);
        t = 0;
        send_byte(8'h5A);
        t += 10 * BITC;
        check(rx_cnt == c0, "R4", "host byte ignored in calibration", rx_cnt - c0, 0);
        while (abd_active && t < 4000) begin
            @(negedge clk);
            t++;
        end
        check(t >= 32 + ABD_EXIT * CPT - 12 && t <= 32 + ABD_EXIT * CPT + 12, "R4",
              "calibration hold", t, 32 + ABD_EXIT * CPT);
        repeat (4) @(negedge clk);
        check(tx_ready, "R4", "ready after calibration", tx_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset_por();
        t_rx_and_gap();
        t_glitch();
        t_core_tx();
        t_framing_drop();
        t_nack();
        t_autobaud();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule